// File: doc/BRIEF.md
# Fixed-Point Recursive Least Squares Weight Engine

This block adapts a four-tap weight vector with the recursive least squares update in 16-bit two's complement arithmetic. Ten of the sixteen bits are fractional. It keeps an inverse-correlation matrix estimate (4x4) and the weight vector in internal registers. A caller presents a new regressor vector and a scalar target with a one-cycle `start` strobe. The block then works through one full update on a single shared multiplier and raises `done` for one cycle. In that cycle the new weights appear on `w_out`.

Each update scales the stored matrix once by the forgetting factor inverse, and that scaled matrix serves two uses. It forms the gain numerator x, and it is the base of the matrix correction. The denominator 1 + uᵀx is inverted by a bit-serial reciprocal stage. After that the gain, the a priori error, the weights and the matrix are updated in a fixed order. The forgetting factor inverse and the initial diagonal value can be loaded while the engine is idle. Loading them also restarts the adaptation.

Top module: `rls_weight_engine`

## Requirements
- R1: After reset, the forgetting factor inverse is 1.0 (1024) and the initial diagonal is 2.0 (2048). The matrix is that diagonal value times the identity, the weights are zero, `w_out` is zero, and `busy` and `done` are low.
- R2: Numbers are signed 16-bit with 10 fractional bits. Each product is the 32-bit product shifted arithmetically right by 10, which rounds toward minus infinity. Every product, sum and difference saturates to the range -32768..32767 instead of wrapping.
- R3: Each update first replaces every matrix entry with its product by the forgetting factor inverse. It then forms x(i) as the saturated sum over j of the products of scaled entry (i,j) and u(j).
- R4: The reciprocal r of den = sat(1024 + Σ u(j)·x(j)) is floor(2^20 / |den|), negated when den is negative, and saturated to 16 bits. A zero den gives +32767.
- R5: The gain is k(i) = x(i)·r.
- R6: The a priori error is alpha = sat(d − Σ w(j)·u(j)), using the weights from before the update. Each weight then becomes sat(w(i) + k(i)·alpha).
- R7: Each scaled matrix entry (i,j) becomes sat(entry − k(i)·x(j)), and the result is kept for the next update.
- R8: `done` is a one-cycle pulse 85 clock cycles after the edge that accepts `start`. `w_out` takes the new weights on that same edge and changes at no other time except reset and a configuration load. `busy` falls the cycle after `done`.
- R9: `busy` is high from the accepting edge through the `done` cycle. A `start` seen while `busy` is high is ignored and leaves results and timing unchanged.
- R10: When idle, `cfg_load` takes priority over `start`. It loads both constants, sets the matrix to the new diagonal times the identity, and clears the weights and `w_out`. A `cfg_load` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load constants and restart adaptation (idle only) |
| cfg_lam_inv | input | 16 | Forgetting factor inverse, Q5.10 |
| cfg_delta_inv | input | 16 | Initial matrix diagonal value, Q5.10 |
| start | input | 1 | Begin one update with `u_in` and `d_in` |
| u_in | input | 64 | Regressor vector, element j at bits [16j+15:16j] |
| d_in | input | 16 | Scalar target, Q5.10 |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle completion pulse |
| w_out | output | 64 | Weight vector, element j at bits [16j+15:16j] |

## Verification
The bench model recomputes the whole update from the requirement formulas as soon as it sees the accepting edge. It holds the result back and counts down 85 edges, because the design needs 16 scaling, 16 matrix-vector, 4 denominator, 21 reciprocal, 4 gain, 4 error, 4 weight and 16 matrix-correction cycles before it enters its completion state. From that count the model predicts `busy`, `done` and `w_out` for every cycle. The bench compares them half a period after each rising edge, so a result that is early or late by a single cycle is reported. Strobes injected mid-update must leave this cycle-exact prediction intact, and a later update shows whether hidden state was disturbed.

// File: rtl/rls_pkg.sv
package rls_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_SCALE, ST_XVEC, ST_DEN, ST_RECIP,
      ST_KVEC, ST_ALPHA, ST_WUPD, ST_PUPD, ST_DONE
   } rls_stage_e;
endpackage

// File: rtl/rls_fx_mul.sv
module rls_fx_mul #(
   parameter int W = 16,
   parameter int F = 10
) (
   input  logic signed [W-1:0] a,
   input  logic signed [W-1:0] b,
   output logic signed [W-1:0] p
);
   localparam int PW = 2 * W;
   localparam logic signed [PW-1:0] HI = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [PW-1:0] LO = ~HI;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shf;

   assign prod = a * b;
   assign shf  = prod >>> F;

   always_comb begin
      if (shf > HI)      p = HI[W-1:0];
      else if (shf < LO) p = LO[W-1:0];
      else               p = shf[W-1:0];
   end
endmodule

// File: rtl/rls_recip.sv
module rls_recip #(
   parameter int W = 16,
   parameter int F = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic signed [W-1:0] den,
   output logic signed [W-1:0] q
);
   localparam int QB = 2 * F + 1;
   localparam int CW = $clog2(QB + 1);
   localparam int EX = ((QB > W) ? QB : W) + 1;
   localparam logic [EX-1:0] LIM = EX'(1) << (W - 1);

   logic [W-1:0]  mag, mag_in;
   logic          neg;
   logic [W-1:0]  rem;
   logic [QB-1:0] quo;
   logic [CW-1:0] step;
   logic [W:0]    rem_n;
   logic [EX-1:0] quo_x;

   assign mag_in = den[W-1] ? W'(-den) : W'(den);
   assign rem_n  = {rem, (step == CW'(QB))};
   assign quo_x  = EX'(quo);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mag  <= '0;
         neg  <= 1'b0;
         rem  <= '0;
         quo  <= '0;
         step <= '0;
      end else if (go) begin
         mag  <= mag_in;
         neg  <= den[W-1];
         rem  <= '0;
         quo  <= '0;
         step <= CW'(QB);
      end else if (step != '0) begin
         if (rem_n >= {1'b0, mag}) begin
            rem <= W'(rem_n - {1'b0, mag});
            quo <= {quo[QB-2:0], 1'b1};
         end else begin
            rem <= rem_n[W-1:0];
            quo <= {quo[QB-2:0], 1'b0};
         end
         step <= step - 1'b1;
      end
   end

   always_comb begin
      if (!neg) q = (quo_x >= LIM) ? {1'b0, {(W-1){1'b1}}} : quo[W-1:0];
      else      q = (quo_x > LIM) ? {1'b1, {(W-1){1'b0}}} : W'(-quo_x);
   end
endmodule

// File: rtl/rls_weight_engine.sv
module rls_weight_engine
   import rls_pkg::*;
#(
   parameter int N             = 4,
   parameter int W             = 16,
   parameter int F             = 10,
   parameter int LAM_INV_RST   = 1024,
   parameter int DELTA_INV_RST = 2048
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_load,
   input  logic [W-1:0]   cfg_lam_inv,
   input  logic [W-1:0]   cfg_delta_inv,
   input  logic           start,
   input  logic [N*W-1:0] u_in,
   input  logic [W-1:0]   d_in,
   output logic           busy,
   output logic           done,
   output logic [N*W-1:0] w_out
);
   localparam int NN    = N * N;
   localparam int LGN   = $clog2(N);
   localparam int QB    = 2 * F + 1;
   localparam int CW    = $clog2(((NN > QB) ? NN : QB) + 1);
   localparam int ACC_W = 2 * W + LGN + 2;
   localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1) << F;
   localparam logic signed [ACC_W-1:0] HI  = {{(ACC_W-W+1){1'b0}}, {(W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] LO  = ~HI;

   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("rls_weight_engine: N must be a power of two, at least 2");
   end
   if (F < 1 || F >= W - 1) begin : g_bad_f
      $error("rls_weight_engine: F must lie in 1..W-2");
   end

   function automatic logic signed [W-1:0] sat(input logic signed [ACC_W-1:0] v);
      if (v > HI)      return HI[W-1:0];
      else if (v < LO) return LO[W-1:0];
      else             return v[W-1:0];
   endfunction

   rls_stage_e stage;
   logic [CW-1:0] cnt, last_cnt;
   logic          last;
   logic [LGN-1:0]   ri, ci;
   logic [2*LGN-1:0] pidx;

   logic signed [W-1:0] pm  [NN];
   logic signed [W-1:0] w_r [N];
   logic signed [W-1:0] wo_r[N];
   logic signed [W-1:0] u_r [N];
   logic signed [W-1:0] x_r [N];
   logic signed [W-1:0] k_r [N];
   logic signed [W-1:0] d_r, alpha, lam, rq, den;
   logic signed [W-1:0] ma, mb, mp;
   logic signed [ACC_W-1:0] acc, sum_now;
   logic div_go;

   assign ri   = cnt[LGN +: LGN];
   assign ci   = cnt[0 +: LGN];
   assign pidx = cnt[2*LGN-1:0];
   assign last = (cnt == last_cnt);

   always_comb begin
      case (stage)
         ST_SCALE, ST_XVEC, ST_PUPD:        last_cnt = CW'(NN - 1);
         ST_DEN, ST_KVEC, ST_ALPHA, ST_WUPD: last_cnt = CW'(N - 1);
         ST_RECIP:                          last_cnt = CW'(QB - 1);
         default:                           last_cnt = '0;
      endcase
   end

   always_comb begin
      ma = '0;
      mb = '0;
      case (stage)
         ST_SCALE: begin ma = lam;      mb = pm[pidx]; end
         ST_XVEC:  begin ma = pm[pidx]; mb = u_r[ci];  end
         ST_DEN:   begin ma = u_r[ci];  mb = x_r[ci];  end
         ST_KVEC:  begin ma = x_r[ci];  mb = rq;       end
         ST_ALPHA: begin ma = w_r[ci];  mb = u_r[ci];  end
         ST_WUPD:  begin ma = k_r[ci];  mb = alpha;    end
         ST_PUPD:  begin ma = k_r[ri];  mb = x_r[ci];  end
         default: ;
      endcase
   end

   rls_fx_mul #(.W(W), .F(F)) i_mul (.a(ma), .b(mb), .p(mp));

   assign sum_now = ((ci == '0) ? '0 : acc) + ACC_W'(mp);
   assign den     = sat(ONE + sum_now);
   assign div_go  = (stage == ST_DEN) && last;

   rls_recip #(.W(W), .F(F)) i_recip (
      .clk(clk), .rst_n(rst_n), .go(div_go), .den(den), .q(rq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage <= ST_IDLE;
         cnt   <= '0;
         acc   <= '0;
         lam   <= W'(LAM_INV_RST);
         d_r   <= '0;
         alpha <= '0;
         for (int e = 0; e < NN; e++)
            pm[e] <= (e % (N + 1) == 0) ? W'(DELTA_INV_RST) : '0;
         for (int e = 0; e < N; e++) begin
            w_r[e] <= '0; wo_r[e] <= '0; u_r[e] <= '0; x_r[e] <= '0; k_r[e] <= '0;
         end
      end else begin
         if (stage != ST_IDLE && stage != ST_DONE)
            cnt <= last ? '0 : cnt + 1'b1;
         case (stage)
            ST_IDLE: begin
               cnt <= '0;
               if (cfg_load) begin
                  lam <= cfg_lam_inv;
                  for (int e = 0; e < NN; e++)
                     pm[e] <= (e % (N + 1) == 0) ? cfg_delta_inv : '0;
                  for (int e = 0; e < N; e++) begin
                     w_r[e] <= '0; wo_r[e] <= '0;
                  end
               end else if (start) begin
                  for (int e = 0; e < N; e++) u_r[e] <= u_in[e*W +: W];
                  d_r   <= d_in;
                  stage <= ST_SCALE;
               end
            end
            ST_SCALE: begin
               pm[pidx] <= mp;
               if (last) stage <= ST_XVEC;
            end
            ST_XVEC: begin
               acc <= sum_now;
               if (ci == LGN'(N - 1)) x_r[ri] <= sat(sum_now);
               if (last) stage <= ST_DEN;
            end
            ST_DEN: begin
               acc <= sum_now;
               if (last) stage <= ST_RECIP;
            end
            ST_RECIP: if (last) stage <= ST_KVEC;
            ST_KVEC: begin
               k_r[ci] <= mp;
               if (last) stage <= ST_ALPHA;
            end
            ST_ALPHA: begin
               acc <= sum_now;
               if (last) begin
                  alpha <= sat(ACC_W'(d_r) - sum_now);
                  stage <= ST_WUPD;
               end
            end
            ST_WUPD: begin
               w_r[ci] <= sat(ACC_W'(w_r[ci]) + ACC_W'(mp));
               if (last) stage <= ST_PUPD;
            end
            ST_PUPD: begin
               pm[pidx] <= sat(ACC_W'(pm[pidx]) - ACC_W'(mp));
               if (last) begin
                  for (int e = 0; e < N; e++) wo_r[e] <= w_r[e];
                  stage <= ST_DONE;
               end
            end
            default: stage <= ST_IDLE;
         endcase
      end
   end

   assign busy = (stage != ST_IDLE);
   assign done = (stage == ST_DONE);

   for (genvar g = 0; g < N; g++) begin : g_wpack
      assign w_out[g*W +: W] = wo_r[g];
   end
endmodule

// File: rtl/rls_weight_engine_chk.sv
module rls_weight_engine_chk #(
   parameter int N = 4,
   parameter int W = 16,
   parameter int F = 10
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           cfg_load,
   input logic           busy,
   input logic           done,
   input logic [N*W-1:0] w_out
);
   localparam int LAT = 3 * N * N + 4 * N + 2 * F + 1;

   logic [15:0] run_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n || !busy) run_cnt <= '0;
      else                 run_cnt <= run_cnt + 1'b1;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_cnt == 16'(LAT))); // R8
   AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !$past(cfg_load)) |-> $stable(w_out)); // R8
   AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R8
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !cfg_load) |=> busy); // R9
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R9
   AST_CFG_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_load && !busy) |=> !busy); // R10
endmodule

bind rls_weight_engine rls_weight_engine_chk #(.N(N), .W(W), .F(F)) i_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .cfg_load(cfg_load),
   .busy(busy), .done(done), .w_out(w_out)
);

// File: tb/test_rls_weight_engine.sv
module test_rls_weight_engine;
   localparam int N   = 4;
   localparam int W   = 16;
   localparam int F   = 10;
   localparam int LAT = 3 * N * N + 4 * N + 2 * F + 1;

   logic           clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0, start = 1'b0;
   logic [W-1:0]   cfg_lam = '0, cfg_dinv = '0, d_in = '0;
   logic [N*W-1:0] u_in = '0;
   wire            busy, done;
   wire [N*W-1:0]  w_out;

   always #2 clk = ~clk;

   rls_weight_engine i_rls_weight_engine (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_lam_inv(cfg_lam),
      .cfg_delta_inv(cfg_dinv), .start(start), .u_in(u_in), .d_in(d_in),
      .busy(busy), .done(done), .w_out(w_out)
   );

   int    n_chk = 0, n_err = 0;
   bit    finished = 0;
   string cur_req = "R1";

   // reference state
   int mP[N][N], mw[N], mwo[N], pw[N];
   int mlam, mdinv, mcnt;
   bit mbusy, mdone;

   function automatic int sat16(input longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return int'(v);
   endfunction

   function automatic int fmul(input int a, input int b);
      longint p = longint'(a) * longint'(b);
      return sat16(p >>> F);
   endfunction

   function automatic int recip(input int den);
      longint mag = (den < 0) ? -den : den;
      longint q;
      if (mag == 0) return 32767;
      q = (longint'(1) << (2 * F)) / mag;
      if (den < 0) return sat16(-q);
      return sat16(q);
   endfunction

   function automatic int sx(input logic [W-1:0] v);
      return int'($signed(v));
   endfunction

   task automatic model_init(input int lam, input int dinv);
      mlam = lam; mdinv = dinv;
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) mP[i][j] = (i == j) ? dinv : 0;
         mw[i] = 0; mwo[i] = 0;
      end
   endtask

   task automatic model_update(input int u[N], input int d);
      int x[N], k[N];
      longint s;
      int r, den, alpha;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) mP[i][j] = fmul(mlam, mP[i][j]);
      for (int i = 0; i < N; i++) begin
         s = 0;
         for (int j = 0; j < N; j++) s += fmul(mP[i][j], u[j]);
         x[i] = sat16(s);
      end
      s = 1 << F;
      for (int j = 0; j < N; j++) s += fmul(u[j], x[j]);
      den = sat16(s);
      r = recip(den);
      for (int i = 0; i < N; i++) k[i] = fmul(x[i], r);
      s = d;
      for (int j = 0; j < N; j++) s -= fmul(mw[j], u[j]);
      alpha = sat16(s);
      for (int i = 0; i < N; i++) mw[i] = sat16(longint'(mw[i]) + fmul(k[i], alpha));
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++)
            mP[i][j] = sat16(longint'(mP[i][j]) - fmul(k[i], x[j]));
      for (int i = 0; i < N; i++) pw[i] = mw[i];
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_init(1024, 2048);
         mbusy = 0; mdone = 0; mcnt = 0;
      end else if (mdone) begin
         mdone = 0; mbusy = 0;
      end else if (mbusy) begin
         mcnt--;
         if (mcnt == 0) begin
            mdone = 1;
            for (int i = 0; i < N; i++) mwo[i] = pw[i];
         end
      end else if (cfg_load) begin
         model_init(sx(cfg_lam), sx(cfg_dinv));
      end else if (start) begin
         int uu[N];
         for (int j = 0; j < N; j++) uu[j] = sx(u_in[j*W +: W]);
         model_update(uu, sx(d_in));
         mbusy = 1; mcnt = LAT;
      end
   end

   // per-cycle comparison, half a period after each edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         n_chk++;
         if (busy !== mbusy) begin
            n_err++;
            $display("FAIL %s/R9 busy actual=%0b expected=%0b t=%0t", cur_req, busy, mbusy, $time);
         end
         if (done !== mdone) begin
            n_err++;
            $display("FAIL %s/R8 done actual=%0b expected=%0b t=%0t", cur_req, done, mdone, $time);
         end
         for (int i = 0; i < N; i++)
            if (sx(w_out[i*W +: W]) !== mwo[i]) begin
               n_err++;
               $display("FAIL %s w_out[%0d] actual=%0d expected=%0d t=%0t",
                        cur_req, i, sx(w_out[i*W +: W]), mwo[i], $time);
            end
      end
   end

   task automatic finish_run;
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   task automatic drive_u(input int u0, input int u1, input int u2, input int u3, input int d);
      u_in = {W'(u3), W'(u2), W'(u1), W'(u0)};
      d_in = W'(d);
   endtask

   task automatic wait_idle;
      do @(negedge clk); while (busy);
      @(negedge clk);
   endtask

   task automatic run_iter(input int u0, input int u1, input int u2, input int u3, input int d);
      @(negedge clk);
      drive_u(u0, u1, u2, u3, d);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
   endtask

   task automatic load_cfg(input int lam, input int dinv);
      @(negedge clk);
      cfg_lam = W'(lam); cfg_dinv = W'(dinv); cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      n_chk++;
      if (w_out !== '0 || busy !== 1'b0 || done !== 1'b0) begin
         n_err++;
         $display("FAIL R1 reset state actual=%h/%0b/%0b expected=0/0/0", w_out, busy, done);
      end
      repeat (4) @(negedge clk);

      // R3 R4 R5 R6 R7 R2: system identification under default constants
      cur_req = "R3_R4_R5_R6_R7";
      for (int n = 0; n < 8; n++) begin
         int u[N];
         int d;
         for (int j = 0; j < N; j++) u[j] = ((n * 37 + j * 53) % 41 - 20) * 25;
         d = (3277 * u[0] + 1126 * u[1] - 2150 * u[2] + 717 * u[3]) >>> 10;
         run_iter(u[0], u[1], u[2], u[3], d);
      end

      // R9 R10: start and cfg_load strobed mid-update must be ignored
      cur_req = "R9_R10";
      @(negedge clk);
      drive_u(300, -200, 150, 400, 250);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      drive_u(-900, 800, 700, -600, 1000);
      start = 1'b1; cfg_load = 1'b1; cfg_lam = 16'd2048; cfg_dinv = 16'd512;
      @(negedge clk);
      start = 1'b0; cfg_load = 1'b0;
      wait_idle();
      run_iter(100, 200, -300, 50, -120);

      // R10: idle cfg_load wins over start and restarts adaptation
      cur_req = "R10";
      @(negedge clk);
      cfg_lam = 16'd1075; cfg_dinv = 16'd20480; cfg_load = 1'b1; start = 1'b1;
      drive_u(500, 500, 500, 500, 500);
      @(negedge clk);
      cfg_load = 1'b0; start = 1'b0;
      repeat (3) @(negedge clk);

      // R2: large operands drive the saturation paths
      cur_req = "R2_R6";
      run_iter(3000, -2500, 2000, 1500, 9000);
      run_iter(-3072, 3072, -1024, 2048, -8000);
      run_iter(2048, 2048, -3000, -3000, 20000);

      // R4: zero denominator gives +max reciprocal
      cur_req = "R4_zero";
      load_cfg(1024, -1024);
      run_iter(1024, 0, 0, 0, 512);

      // R4: negative denominator gives a negated reciprocal
      cur_req = "R4_neg";
      load_cfg(1024, -2048);
      run_iter(1024, 0, 0, 0, 300);
      run_iter(512, -512, 256, 0, -200);

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule